// File: doc/BRIEF.md
# Row-Committing Serial Array Write Sequencer

This block sits behind a byte-oriented serial bus front end and manages writes into a small non-volatile array of 8 rows of 6 bytes. Rather than raw bus signals, it takes decoded bus events: start, stop, address-byte strobe and data-byte strobe. It also takes a write-enable level from a control register. A row/column pointer selects the target byte. Accepted data bytes collect in a one-row staging buffer. When the byte for the last column arrives, the whole row is committed in one programming operation. After the commit, the block stays busy for a fixed, parameterised number of cycles.

While the block is busy, it ignores array traffic. If a new bus transfer opens during that time, it asks the front end to hold the serial clock low. A stop that arrives before a row is complete discards the staged bytes and leaves the array untouched. A read port returns the byte at the pointer and steps the column in the same way as a write does.

The byte address carries the column in its low 3 bits and the row in the next 3 bits. A column code of 6 or 7 is invalid and is replaced by 0.

Top module: `eew_row_writer`

## Requirements
- R1: An address strobe while idle loads the row from addr_i[5:3] and, when addr_i[2:0] is below 6, the column from addr_i[2:0]. The new pointer appears on ptr_row_o/ptr_col_o on the next cycle.
- R2: An address whose column field is 6 or 7 loads column 0, and its row field is loaded unchanged.
- R3: A data byte accepted while the enable is high is staged at the pointer column, and the column advances by one. The array contents are not changed until the row commits.
- R4: A data byte accepted at column 5 commits the row in one step. Staged bytes and the new byte replace their positions, and positions not written since the last address load keep their old values. The column returns to 0 and the row stays the same.
- R5: After a commit, busy_o is high for exactly BUSY_CYCLES consecutive cycles, starting on the cycle after the committing byte.
- R6: While busy_o is high, address, data and read strobes have no effect on the pointer, the staging buffer or the array.
- R7: hold_scl_o is high only while busy_o is high and a start has been seen with no stop since. It falls when the busy period ends.
- R8: A stop discards all staged bytes. The array row keeps its contents, and a later commit of that row does not include the discarded bytes.
- R9: While prog_en_i is low, data strobes change neither the pointer nor the array, and address strobes still load the pointer.
- R10: rd_data_o shows the array byte at the pointer one cycle after the pointer settles and holds its value while busy. A read strobe advances the column, wrapping from 5 to 0 without a commit.
- R11: After reset the pointer is row 0 / column 0, busy_o and hold_scl_o are low, and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Bus start event strobe |
| stop_i | input | 1 | Bus stop event strobe |
| addr_vld_i | input | 1 | Address byte strobe |
| addr_i | input | 6 | Byte address: row in [5:3], column in [2:0] |
| data_vld_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| prog_en_i | input | 1 | Array write enable from control register |
| rd_i | input | 1 | Read strobe, advances the column |
| rd_data_o | output | 8 | Byte at the pointer |
| busy_o | output | 1 | Programming period in progress |
| hold_scl_o | output | 1 | Request to hold the serial clock low |
| ptr_row_o | output | 3 | Pointer row |
| ptr_col_o | output | 3 | Pointer column |

## Verification
Some properties can be checked on every cycle. These are the exact length of each busy period, a legal column value, and the requirement that a clock-hold request occurs only while busy. They also include a frozen pointer and frozen read data during programming, the pointer load from a valid address, and the absence of pointer movement when data arrives with the enable low. Other behaviours need an ordered sequence of events, so only the bench scenarios can show them. These are the row-merge contents after a commit, the discarding of partial rows on stop, and the wrap of the column under reads.

// File: rtl/eew_pkg.sv
package eew_pkg;
   // Decoded action taken by the sequencer in a given cycle
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_ADDR = 2'd1,
      EV_DATA = 2'd2,
      EV_READ = 2'd3
   } evt_e;
endpackage

// File: rtl/eew_addr_ptr.sv
module eew_addr_ptr
   import eew_pkg::*;
#(
   parameter int COLS  = 6,
   parameter int ROW_W = 3,
   parameter int COL_W = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  evt_e                   ev_i,
   input  logic [ROW_W+COL_W-1:0] addr_i,
   output logic [ROW_W-1:0]       row_o,
   output logic [COL_W-1:0]       col_o
);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
   localparam logic [COL_W-1:0] NUM_COLS = COL_W'(COLS);

   logic [COL_W-1:0] req_col;
   logic [COL_W-1:0] load_col;

   assign req_col = addr_i[COL_W-1:0];

   // Column codes beyond the row width collapse to column 0
   generate
      if (COLS == (1 << COL_W)) begin : g_full_cols
         assign load_col = req_col;
      end else begin : g_part_cols
         assign load_col = (req_col < NUM_COLS) ? req_col : '0;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         row_o <= '0;
         col_o <= '0;
      end else begin
         unique case (ev_i)
            EV_ADDR: begin
               row_o <= addr_i[ROW_W+COL_W-1:COL_W];
               col_o <= load_col;
            end
            EV_DATA, EV_READ: col_o <= (col_o == LAST_COL) ? '0 : col_o + 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/eew_row_buf.sv
module eew_row_buf #(
   parameter int COLS   = 6,
   parameter int COL_W  = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              wr_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] slot_o [COLS],
   output logic [COLS-1:0]   mask_o
);
   generate
      for (genvar c = 0; c < COLS; c++) begin : g_slot
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               slot_o[c] <= '0;
               mask_o[c] <= 1'b0;
            end else if (clear_i) begin
               mask_o[c] <= 1'b0;
            end else if (wr_i && (col_i == COL_W'(c))) begin
               slot_o[c] <= data_i;
               mask_o[c] <= 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/eew_busy_timer.sv
module eew_busy_timer #(
   parameter int BUSY_CYCLES = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   output logic busy_o
);
   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) cnt_q <= '0;
      else if (load_i) cnt_q <= CNT_W'(BUSY_CYCLES);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eew_row_writer.sv
module eew_row_writer
   import eew_pkg::*;
#(
   parameter int ROWS        = 8,
   parameter int COLS        = 6,
   parameter int DATA_W      = 8,
   parameter int BUSY_CYCLES = 16,
   parameter int ROW_W       = $clog2(ROWS),
   parameter int COL_W       = $clog2(COLS)
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   start_i,
   input  logic                   stop_i,
   input  logic                   addr_vld_i,
   input  logic [ROW_W+COL_W-1:0] addr_i,
   input  logic                   data_vld_i,
   input  logic [DATA_W-1:0]      data_i,
   input  logic                   prog_en_i,
   input  logic                   rd_i,
   output logic [DATA_W-1:0]      rd_data_o,
   output logic                   busy_o,
   output logic                   hold_scl_o,
   output logic [ROW_W-1:0]       ptr_row_o,
   output logic [COL_W-1:0]       ptr_col_o
);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

   // Elaboration-time parameter checks
   if (COLS < 2) begin : g_chk_cols
      $error("eew_row_writer: COLS must be at least 2");
   end
   if (ROWS != (1 << ROW_W)) begin : g_chk_rows
      $error("eew_row_writer: ROWS must be a power of two");
   end
   if (BUSY_CYCLES < 1) begin : g_chk_busy
      $error("eew_row_writer: BUSY_CYCLES must be at least 1");
   end
   if (DATA_W < 1) begin : g_chk_dw
      $error("eew_row_writer: DATA_W must be positive");
   end

   evt_e             ev;
   logic             commit;
   logic             xfer_q;
   logic [DATA_W-1:0] mem_q  [ROWS][COLS];
   logic [DATA_W-1:0] slot   [COLS];
   logic [DATA_W-1:0] merged [COLS];
   logic [COLS-1:0]  mask;
   logic [DATA_W-1:0] rd_q;

   // Busy gates all array traffic; address outranks data, data outranks read
   always_comb begin
      ev = EV_NONE;
      if (!busy_o) begin
         if (addr_vld_i) ev = EV_ADDR;
         else if (data_vld_i) ev = prog_en_i ? EV_DATA : EV_NONE;
         else if (rd_i) ev = EV_READ;
      end
   end

   assign commit = (ev == EV_DATA) && (ptr_col_o == LAST_COL);

   eew_addr_ptr #(.COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (ev),
      .addr_i (addr_i),
      .row_o  (ptr_row_o),
      .col_o  (ptr_col_o)
   );

   eew_row_buf #(.COLS(COLS), .COL_W(COL_W), .DATA_W(DATA_W)) u_buf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (stop_i || commit || (ev == EV_ADDR)),
      .wr_i    (ev == EV_DATA),
      .col_i   (ptr_col_o),
      .data_i  (data_i),
      .slot_o  (slot),
      .mask_o  (mask)
   );

   eew_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (commit),
      .busy_o (busy_o)
   );

   // Row image to commit: new byte, else staged byte, else current content
   generate
      for (genvar c = 0; c < COLS; c++) begin : g_merge
         always_comb begin
            if (c == COLS - 1) merged[c] = data_i;
            else if (mask[c]) merged[c] = slot[c];
            else merged[c] = mem_q[ptr_row_o][c];
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) mem_q[r][c] <= '0;
         end
      end else if (commit) begin
         for (int c = 0; c < COLS; c++) mem_q[ptr_row_o][c] <= merged[c];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) rd_q <= '0;
      else if (!busy_o) rd_q <= mem_q[ptr_row_o][ptr_col_o];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) xfer_q <= 1'b0;
      else if (stop_i) xfer_q <= 1'b0;
      else if (start_i) xfer_q <= 1'b1;
   end

   assign rd_data_o  = rd_q;
   assign hold_scl_o = busy_o && xfer_q;
endmodule

// File: rtl/eew_row_writer_chk.sv
module eew_row_writer_chk #(
   parameter int COLS        = 6,
   parameter int BUSY_CYCLES = 16,
   parameter int DATA_W      = 8,
   parameter int ROW_W       = 3,
   parameter int COL_W       = 3
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   addr_vld_i,
   input logic [ROW_W+COL_W-1:0] addr_i,
   input logic                   data_vld_i,
   input logic                   prog_en_i,
   input logic                   rd_i,
   input logic [DATA_W-1:0]      rd_data_o,
   input logic                   busy_o,
   input logic                   hold_scl_o,
   input logic [ROW_W-1:0]       ptr_row_o,
   input logic [COL_W-1:0]       ptr_col_o
);
   int unsigned busy_run;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !busy_o) busy_run <= 0;
      else busy_run <= busy_run + 1;
   end

   // R5: busy period never exceeds, and ends at, the programmed length
   a_r5_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> busy_run < BUSY_CYCLES);
   a_r5_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> busy_run == BUSY_CYCLES);

   // R7: clock hold only requested during programming
   a_r7_hold_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_scl_o |-> busy_o);

   // R2: pointer column always within the row
   a_r2_col_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptr_col_o < COL_W'(COLS));

   // R6: pointer frozen during programming
   a_r6_ptr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> ($stable(ptr_row_o) && $stable(ptr_col_o)));

   // R10: read data held during programming
   a_r10_rd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> $stable(rd_data_o));

   // R1: valid address loads the pointer
   a_r1_addr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && addr_vld_i && (addr_i[COL_W-1:0] < COL_W'(COLS))) |=>
      (ptr_col_o == $past(addr_i[COL_W-1:0]) &&
       ptr_row_o == $past(addr_i[ROW_W+COL_W-1:COL_W])));

   // R9: disabled data strobe leaves the pointer alone
   a_r9_no_move_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !addr_vld_i && data_vld_i && !prog_en_i) |=>
      ($stable(ptr_col_o) && $stable(ptr_row_o)));
endmodule

bind eew_row_writer eew_row_writer_chk #(
   .COLS(COLS), .BUSY_CYCLES(BUSY_CYCLES), .DATA_W(DATA_W),
   .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .addr_vld_i (addr_vld_i),
   .addr_i     (addr_i),
   .data_vld_i (data_vld_i),
   .prog_en_i  (prog_en_i),
   .rd_i       (rd_i),
   .rd_data_o  (rd_data_o),
   .busy_o     (busy_o),
   .hold_scl_o (hold_scl_o),
   .ptr_row_o  (ptr_row_o),
   .ptr_col_o  (ptr_col_o)
);

// File: tb/eew_row_writer_tb_top.sv
module eew_row_writer_tb_top;
   localparam int BUSY = 12;

   // Table opcodes
   localparam logic [2:0] OP_ADDR = 3'd0;
   localparam logic [2:0] OP_DATA = 3'd1;
   localparam logic [2:0] OP_STOP = 3'd2;
   localparam logic [2:0] OP_CHKP = 3'd3;   // expect {row,col}
   localparam logic [2:0] OP_CHKR = 3'd4;   // expect rd_data_o
   localparam logic [2:0] OP_READ = 3'd5;
   localparam logic [2:0] OP_WAIT = 3'd6;

   localparam int NV = 47;
   // entry = {op, arg, expected}
   localparam logic [18:0] VEC [NV] = '{
      {OP_ADDR, 8'h10, 8'h00},
      {OP_CHKP, 8'h00, 8'h10},   // R1 row 2 col 0
      {OP_DATA, 8'h11, 8'h00},
      {OP_DATA, 8'h22, 8'h00},
      {OP_DATA, 8'h33, 8'h00},
      {OP_CHKP, 8'h00, 8'h13},   // R3 column advanced
      {OP_STOP, 8'h00, 8'h00},
      {OP_ADDR, 8'h10, 8'h00},
      {OP_CHKR, 8'h00, 8'h00},   // R8 row untouched after stop
      {OP_ADDR, 8'h0E, 8'h00},
      {OP_CHKP, 8'h00, 8'h08},   // R2 col 6 -> 0
      {OP_ADDR, 8'h1F, 8'h00},
      {OP_CHKP, 8'h00, 8'h18},   // R2 col 7 -> 0
      {OP_ADDR, 8'h0C, 8'h00},
      {OP_DATA, 8'hA4, 8'h00},
      {OP_CHKR, 8'h00, 8'h00},   // R3 array not yet written
      {OP_DATA, 8'hA5, 8'h00},
      {OP_WAIT, 8'h00, 8'h00},
      {OP_CHKP, 8'h00, 8'h08},   // R4 col back to 0, same row
      {OP_CHKR, 8'h00, 8'h00},   // R4 unwritten position kept
      {OP_ADDR, 8'h0D, 8'h00},
      {OP_CHKR, 8'h00, 8'hA5},   // R4 committed byte
      {OP_READ, 8'h00, 8'h00},
      {OP_CHKP, 8'h00, 8'h08},   // R10 read wraps 5 -> 0
      {OP_CHKR, 8'h00, 8'h00},
      {OP_ADDR, 8'h0C, 8'h00},
      {OP_CHKR, 8'h00, 8'hA4},   // R4 staged byte committed
      {OP_ADDR, 8'h28, 8'h00},
      {OP_DATA, 8'h50, 8'h00},
      {OP_DATA, 8'h51, 8'h00},
      {OP_DATA, 8'h52, 8'h00},
      {OP_DATA, 8'h53, 8'h00},
      {OP_DATA, 8'h54, 8'h00},
      {OP_DATA, 8'h55, 8'h00},
      {OP_WAIT, 8'h00, 8'h00},
      {OP_ADDR, 8'h2B, 8'h00},
      {OP_CHKR, 8'h00, 8'h53},   // R4 full row
      {OP_READ, 8'h00, 8'h00},
      {OP_CHKR, 8'h00, 8'h54},   // R10 read advances
      {OP_CHKP, 8'h00, 8'h2C},
      {OP_ADDR, 8'h15, 8'h00},
      {OP_DATA, 8'h77, 8'h00},
      {OP_WAIT, 8'h00, 8'h00},
      {OP_ADDR, 8'h10, 8'h00},
      {OP_CHKR, 8'h00, 8'h00},   // R8 discarded bytes absent
      {OP_ADDR, 8'h15, 8'h00},
      {OP_CHKR, 8'h00, 8'h77}
   };

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       start_i = 1'b0, stop_i = 1'b0;
   logic       addr_vld_i = 1'b0, data_vld_i = 1'b0;
   logic [5:0] addr_i = '0;
   logic [7:0] data_i = '0;
   logic       prog_en_i = 1'b1, rd_i = 1'b0;
   logic [7:0] rd_data_o;
   logic       busy_o, hold_scl_o;
   logic [2:0] ptr_row_o, ptr_col_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk_i = ~clk_i;

   eew_row_writer #(.BUSY_CYCLES(BUSY)) dut_i (
      .clk_i, .rst_ni, .start_i, .stop_i, .addr_vld_i, .addr_i,
      .data_vld_i, .data_i, .prog_en_i, .rd_i, .rd_data_o,
      .busy_o, .hold_scl_o, .ptr_row_o, .ptr_col_o
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step_addr(input logic [5:0] a);
      addr_vld_i = 1'b1; addr_i = a;
      @(negedge clk_i); addr_vld_i = 1'b0;
      @(negedge clk_i);
   endtask

   task automatic step_data(input logic [7:0] d);
      data_vld_i = 1'b1; data_i = d;
      @(negedge clk_i); data_vld_i = 1'b0;
      @(negedge clk_i);
   endtask

   task automatic step_pulse_stop();
      stop_i = 1'b1;
      @(negedge clk_i); stop_i = 1'b0;
      @(negedge clk_i);
   endtask

   task automatic step_read();
      rd_i = 1'b1;
      @(negedge clk_i); rd_i = 1'b0;
      @(negedge clk_i);
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (busy_o && guard < 1000) begin
         guard++;
         @(negedge clk_i);
      end
      @(negedge clk_i);
   endtask

   initial begin
      repeat (100000) @(posedge clk_i);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      // R11 reset state
      check("R11 ptr", {ptr_row_o, ptr_col_o}, 0);
      check("R11 busy", busy_o, 0);
      check("R11 hold", hold_scl_o, 0);
      check("R11 rd_data", rd_data_o, 0);

      for (int i = 0; i < NV; i++) begin
         logic [2:0] op;
         logic [7:0] arg, exp;
         {op, arg, exp} = VEC[i];
         case (op)
            OP_ADDR: step_addr(arg[5:0]);
            OP_DATA: step_data(arg);
            OP_STOP: step_pulse_stop();
            OP_READ: step_read();
            OP_WAIT: wait_idle();
            OP_CHKP: check($sformatf("R1/R2/R3/R4/R10 pointer step %0d", i),
                           {ptr_row_o, ptr_col_o}, exp);
            OP_CHKR: check($sformatf("R3/R4/R8/R10 read step %0d", i),
                           rd_data_o, exp);
            default: ;
         endcase
      end

      // R9: enable low, address loads, data ignored
      prog_en_i = 1'b0;
      step_addr(6'h38);
      check("R9 addr loads while disabled", {ptr_row_o, ptr_col_o}, 8'h38);
      step_data(8'h99);
      check("R9 pointer unchanged", {ptr_row_o, ptr_col_o}, 8'h38);
      check("R9 array unchanged", rd_data_o, 0);
      prog_en_i = 1'b1;

      // R5 / R6 / R7: commit row 6, then poke during busy
      step_addr(6'h30);
      for (int b = 0; b < 5; b++) step_data(8'(8'h60 + b));
      data_vld_i = 1'b1; data_i = 8'h65;
      @(negedge clk_i); data_vld_i = 1'b0;
      check("R5 busy after commit", busy_o, 1);
      cnt = 0;
      while (busy_o && cnt < 100) begin
         start_i    = (cnt == 2);
         addr_vld_i = (cnt == 5);
         addr_i     = 6'h3F;
         data_vld_i = (cnt == 6);
         rd_i       = (cnt == 7);
         if (cnt == 4) check("R7 hold during busy", hold_scl_o, 1);
         cnt++;
         @(negedge clk_i);
      end
      start_i = 1'b0; addr_vld_i = 1'b0; data_vld_i = 1'b0; rd_i = 1'b0;
      check("R5 busy length", cnt, BUSY);
      check("R7 hold released", hold_scl_o, 0);
      check("R6 pointer ignored strobes", {ptr_row_o, ptr_col_o}, 8'h30);
      step_pulse_stop();
      step_addr(6'h33);
      check("R4 row 6 byte 3", rd_data_o, 8'h63);
      step_addr(6'h30);
      check("R6 data during busy ignored", rd_data_o, 8'h60);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule